// File: doc/BRIEF.md
# ADC Sample Post-Processor

This block sits between the digital output of an analog-to-digital converter and the register that software reads. It accepts one 12-bit unsigned sample per strobe and can transform the sample before it reaches the result register. A three-bit mode input chooses the treatment:
- **Forward:** the sample passes unchanged.
- **Accumulate:** a programmable number of samples is summed and one result comes out per block.
- **Three-tap FIR:** a weighted sum of the current and two previous samples.
- **First-order IIR:** a smoothing filter that follows the input.
- **Difference:** a reference value is subtracted from the sample.

The filter weights come from a small fixed table, indexed by a 2-bit select. Every weight is a power-of-two fraction, so the filters need only shifts and adds. Each result is registered. A one-cycle event pulse marks every new result. A sticky valid flag stays set until the consumer pulses a read strobe.

Top module: `adc_postproc`

## Requirements
- R1: While reset is held, and in the first cycle after it, `res_data` is 0 and both `res_valid` and `res_event` are 0.
- R2: Forward mode has mode code 0. Codes 5, 6 and 7 behave the same way. In this mode, each accepted sample appears zero-extended on `res_data` one cycle later, with `res_event` high.
- R3: Accumulate mode has mode code 1. It sums N = `acc_len_m1`+1 consecutive samples, where N is 1 to 16. On the Nth sample it outputs the 16-bit sum, raises `res_event` and restarts from zero. The sum of sixteen samples of 4095 is 65520, with no overflow. If N is lowered below the number of samples already taken, the next sample ends the block.
- R4: With `acc_len_m1` = 3, exactly one result comes out per four input samples, and its value is four times their average.
- R5: FIR mode has mode code 2. The result is (w0·x[n] + w1·x[n-1] + w2·x[n-2]) / 4, rounded down. The weights (w0,w1,w2) are set by `coef_sel`: 0 gives (2,1,1), 1 gives (1,2,1), 2 gives (4,0,0) and 3 gives (2,2,0). An event is raised for every sample.
- R6: IIR mode has mode code 3. With state y, each sample x updates y to y + floor((x − y) / 2^k), where k = `coef_sel`+1. The new y is output, with an event raised for every sample.
- R7: Difference mode has mode code 4. The output is `smp_data` − `ref_value`, sign-extended to 16-bit two's complement. An event is raised for every sample.
- R8: Whenever `mode` differs from its value in the previous cycle, the FIR history, the IIR state and the accumulator sum and count are all treated as zero.
- R9: `res_valid` rises in the same cycle as `res_event`. It stays set until a cycle with `rd_strobe` high and no new result. A new result in the same cycle as a read keeps it set.
- R10: `res_event` is only high in the cycle after an accepted sample that completes a result. In every other cycle, `res_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 12 | Raw unsigned converter sample |
| mode | input | 3 | Treatment select (0 forward, 1 accumulate, 2 FIR, 3 IIR, 4 difference) |
| coef_sel | input | 2 | Filter weight select |
| acc_len_m1 | input | 4 | Accumulation length minus one |
| ref_value | input | 12 | Reference subtracted in difference mode |
| rd_strobe | input | 1 | Consumer read pulse, clears the valid flag |
| res_data | output | 16 | Processed result |
| res_valid | output | 1 | Sticky result-available flag |
| res_event | output | 1 | One-cycle pulse per new result |

## Verification
A corrupted FIR history or IIR state shows up as a wrong `res_data` on the very next sample, because every filtered sample produces an event. A wrong accumulator count shows up differently: the event arrives at the wrong sample, or arrives with a sum that includes too many or too few inputs, so it can stay hidden for as many as sixteen samples. A mode-change clear that is skipped only shows up on the first sample after the switch. For that reason the filter and accumulator modes are each re-entered after a detour and then checked on their first output.

// File: rtl/adc_pp_pkg.sv
package adc_pp_pkg;

    localparam int SMP_W  = 12;
    localparam int RES_W  = 16;
    localparam int LEN_W  = 4;
    localparam int NTAPS  = 3;

    typedef enum logic [2:0] {
        PP_PASS  = 3'd0,
        PP_ACCUM = 3'd1,
        PP_FIR   = 3'd2,
        PP_IIR   = 3'd3,
        PP_DIFF  = 3'd4
    } pp_mode_e;

    typedef struct packed {
        logic [RES_W-1:0] data;
        logic             fire;
    } pp_result_t;

    // Weight code per tap: 0 -> x0, 1 -> x1, 2 -> x2, 3 -> x4 (quarters)
    function automatic logic [1:0] fir_code(input logic [1:0] sel, input int tap);
        logic [5:0] row;
        case (sel)
            2'd0:    row = {2'd1, 2'd1, 2'd2};
            2'd1:    row = {2'd1, 2'd2, 2'd1};
            2'd2:    row = {2'd0, 2'd0, 2'd3};
            default: row = {2'd0, 2'd2, 2'd2};
        endcase
        return row[tap*2 +: 2];
    endfunction

    function automatic logic [SMP_W+1:0] fir_term(input logic [SMP_W-1:0] x,
                                                  input logic [1:0] code);
        logic [SMP_W+1:0] xe;
        xe = {2'b00, x};
        case (code)
            2'd0:    return '0;
            2'd1:    return xe;
            2'd2:    return xe << 1;
            default: return xe << 2;
        endcase
    endfunction

endpackage

// File: rtl/adc_pp_accum.sv
module adc_pp_accum #(
    parameter int SMP_W = 12,
    parameter int SUM_W = 16,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [SMP_W-1:0] x,
    input  logic [LEN_W-1:0] len_m1,
    output logic [SUM_W-1:0] sum_next,
    output logic             done
);
    logic [SUM_W-1:0] sum_q, sum_base;
    logic [LEN_W-1:0] cnt_q, cnt_base;

    always_comb begin
        sum_base = clr ? '0 : sum_q;
        cnt_base = clr ? '0 : cnt_q;
        sum_next = sum_base + SUM_W'(x);
        done     = (cnt_base >= len_m1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (en) begin
            if (done) begin
                sum_q <= '0;
                cnt_q <= '0;
            end else begin
                sum_q <= sum_next;
                cnt_q <= cnt_base + 1'b1;
            end
        end else if (clr) begin
            sum_q <= '0;
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/adc_pp_fir.sv
module adc_pp_fir
    import adc_pp_pkg::*;
#(
    parameter int SMP_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [1:0]       sel,
    input  logic [SMP_W-1:0] x,
    output logic [SMP_W-1:0] y
);
    localparam int ACC_W = SMP_W + 4;

    logic [SMP_W-1:0] tap_x [NTAPS];
    logic [SMP_W-1:0] tap_q [1:NTAPS-1];
    logic [SMP_W+1:0] term  [NTAPS];
    logic [ACC_W-1:0] acc;

    assign tap_x[0] = x;

    for (genvar i = 1; i < NTAPS; i++) begin : g_tap
        assign tap_x[i] = clr ? '0 : tap_q[i];
        always_ff @(posedge clk) begin
            if (rst)
                tap_q[i] <= '0;
            else if (en)
                tap_q[i] <= tap_x[i-1];
            else if (clr)
                tap_q[i] <= '0;
        end
    end

    for (genvar i = 0; i < NTAPS; i++) begin : g_term
        assign term[i] = fir_term(tap_x[i], fir_code(sel, i));
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < NTAPS; i++)
            acc = acc + ACC_W'(term[i]);
    end

    assign y = acc[SMP_W+1:2];

endmodule

// File: rtl/adc_pp_iir.sv
module adc_pp_iir #(
    parameter int SMP_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [1:0]       sel,
    input  logic [SMP_W-1:0] x,
    output logic [SMP_W-1:0] y
);
    logic [SMP_W-1:0]        y_q, y_base;
    logic signed [SMP_W+1:0] delta, step, total;
    logic [2:0]              k;

    always_comb begin
        y_base = clr ? '0 : y_q;
        k      = {1'b0, sel} + 3'd1;
        delta  = $signed({2'b00, x}) - $signed({2'b00, y_base});
        step   = delta >>> k;
        total  = $signed({2'b00, y_base}) + step;
        y      = total[SMP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            y_q <= '0;
        else if (en)
            y_q <= y;
        else if (clr)
            y_q <= '0;
    end

endmodule

// File: rtl/adc_postproc.sv
module adc_postproc
    import adc_pp_pkg::*;
#(
    parameter int SMP_W = adc_pp_pkg::SMP_W,
    parameter int RES_W = adc_pp_pkg::RES_W,
    parameter int LEN_W = adc_pp_pkg::LEN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic [2:0]       mode,
    input  logic [1:0]       coef_sel,
    input  logic [LEN_W-1:0] acc_len_m1,
    input  logic [SMP_W-1:0] ref_value,
    input  logic             rd_strobe,
    output logic [RES_W-1:0] res_data,
    output logic             res_valid,
    output logic             res_event
);
    localparam int PAD_W = RES_W - SMP_W;

    logic [2:0]              mode_q;
    logic                    mode_chg;
    logic                    en_acc, en_fir, en_iir;
    logic [RES_W-1:0]        acc_sum;
    logic                    acc_done;
    logic [SMP_W-1:0]        fir_y, iir_y;
    logic signed [SMP_W:0]   diff_v;
    pp_result_t              nxt;

    assign mode_chg = (mode != mode_q);
    assign en_acc   = smp_valid && (mode == PP_ACCUM);
    assign en_fir   = smp_valid && (mode == PP_FIR);
    assign en_iir   = smp_valid && (mode == PP_IIR);

    adc_pp_accum #(.SMP_W(SMP_W), .SUM_W(RES_W), .LEN_W(LEN_W)) u_accum (
        .clk(clk), .rst(rst), .clr(mode_chg), .en(en_acc), .x(smp_data),
        .len_m1(acc_len_m1), .sum_next(acc_sum), .done(acc_done)
    );

    adc_pp_fir #(.SMP_W(SMP_W)) u_fir (
        .clk(clk), .rst(rst), .clr(mode_chg), .en(en_fir), .sel(coef_sel),
        .x(smp_data), .y(fir_y)
    );

    adc_pp_iir #(.SMP_W(SMP_W)) u_iir (
        .clk(clk), .rst(rst), .clr(mode_chg), .en(en_iir), .sel(coef_sel),
        .x(smp_data), .y(iir_y)
    );

    assign diff_v = $signed({1'b0, smp_data}) - $signed({1'b0, ref_value});

    always_comb begin
        nxt.fire = 1'b1;
        case (mode)
            PP_ACCUM: begin
                nxt.data = acc_sum;
                nxt.fire = acc_done;
            end
            PP_FIR:  nxt.data = {{PAD_W{1'b0}}, fir_y};
            PP_IIR:  nxt.data = {{PAD_W{1'b0}}, iir_y};
            PP_DIFF: nxt.data = {{(PAD_W-1){diff_v[SMP_W]}}, diff_v};
            default: nxt.data = {{PAD_W{1'b0}}, smp_data};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= PP_PASS;
            res_data  <= '0;
            res_valid <= 1'b0;
            res_event <= 1'b0;
        end else begin
            mode_q    <= mode;
            res_event <= smp_valid && nxt.fire;
            if (smp_valid && nxt.fire) begin
                res_data  <= nxt.data;
                res_valid <= 1'b1;
            end else if (rd_strobe) begin
                res_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adc_postproc_chk.sv
module adc_postproc_chk #(
    parameter int SMP_W = 12,
    parameter int RES_W = 16,
    parameter int LEN_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_valid,
    input logic [SMP_W-1:0] smp_data,
    input logic [2:0]       mode,
    input logic [1:0]       coef_sel,
    input logic [LEN_W-1:0] acc_len_m1,
    input logic [SMP_W-1:0] ref_value,
    input logic             rd_strobe,
    input logic [RES_W-1:0] res_data,
    input logic             res_valid,
    input logic             res_event
);
    logic signed [RES_W-1:0] diff_ref;
    assign diff_ref = RES_W'($signed({1'b0, smp_data}) - $signed({1'b0, ref_value}));

    // R9
    event_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
        res_event |-> res_valid);

    // R9
    read_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !smp_valid) |=> !res_valid);

    // R9
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !rd_strobe) |=> res_valid);

    // R10
    no_sample_no_event_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !res_event);

    // R10
    data_held_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(res_data));

    // R2
    forward_value_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && mode == 3'd0) |=> (res_event && res_data == RES_W'($past(smp_data))));

    // R7
    diff_value_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && mode == 3'd4) |=> (res_event && res_data == $past(diff_ref)));

    // R3
    single_len_fires_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && mode == 3'd1 && acc_len_m1 == '0) |=> res_event);

endmodule

bind adc_postproc adc_postproc_chk #(.SMP_W(SMP_W), .RES_W(RES_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/adc_postproc_bench.sv
module adc_postproc_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic [2:0]  mode = 3'd0;
    logic [1:0]  coef_sel = '0;
    logic [3:0]  acc_len_m1 = '0;
    logic [11:0] ref_value = '0;
    logic        rd_strobe = 1'b0;
    logic [15:0] res_data;
    logic        res_valid;
    logic        res_event;

    always #5 clk = ~clk;

    adc_postproc u_adc_postproc (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .mode(mode), .coef_sel(coef_sel), .acc_len_m1(acc_len_m1),
        .ref_value(ref_value), .rd_strobe(rd_strobe), .res_data(res_data),
        .res_valid(res_valid), .res_event(res_event)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    int m_h1, m_h2, m_iy, m_sum, m_cnt, last_out, cur_mode;

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_model();
        m_h1 = 0; m_h2 = 0; m_iy = 0; m_sum = 0; m_cnt = 0;
    endtask

    task automatic set_mode(input int m);
        if (m != cur_mode) clear_model();
        cur_mode = m;
        mode = 3'(m);
    endtask

    function automatic int fir_w(input int sel, input int tap);
        int w [4][3] = '{'{2,1,1}, '{1,2,1}, '{4,0,0}, '{2,2,0}};
        return w[sel][tap];
    endfunction

    task automatic push(input int x, input string req);
        int exp_v;
        int ev;
        int d;
        smp_data  = 12'(x);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        ev = 1;
        case (cur_mode)
            1: begin
                m_sum += x;
                m_cnt++;
                if (m_cnt >= int'(acc_len_m1) + 1) begin
                    exp_v = m_sum; m_sum = 0; m_cnt = 0;
                end else begin
                    ev = 0; exp_v = last_out;
                end
            end
            2: begin
                exp_v = (fir_w(coef_sel,0)*x + fir_w(coef_sel,1)*m_h1
                         + fir_w(coef_sel,2)*m_h2) / 4;
                m_h2 = m_h1; m_h1 = x;
            end
            3: begin
                d = x - m_iy;
                m_iy = m_iy + (d >>> (int'(coef_sel) + 1));
                exp_v = m_iy;
            end
            4: exp_v = (x - int'(ref_value)) & 16'hFFFF;
            default: exp_v = x;
        endcase
        check({req, " event"}, int'(res_event), ev);
        check({req, " data"}, int'(res_data), exp_v);
        last_out = exp_v;
    endtask

    initial begin
        cur_mode = 0; last_out = 0; clear_model();
        repeat (3) @(negedge clk);
        // R1: held in reset
        check("R1 data", int'(res_data), 0);
        check("R1 valid", int'(res_valid), 0);
        check("R1 event", int'(res_event), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 post-reset valid", int'(res_valid), 0);

        // R2: forward sweep, including aliased codes
        set_mode(0);
        for (int x = 0; x < 4096; x += 91) push(x, "R2 forward");
        push(4095, "R2 full scale");
        set_mode(5); push(1234, "R2 code5");
        set_mode(7); push(77, "R2 code7");

        // R3: every accumulation length, two blocks each; R10 between results
        set_mode(1);
        for (int len = 1; len <= 16; len++) begin
            acc_len_m1 = 4'(len - 1);
            for (int i = 0; i < 2 * len; i++) push((i * 523 + len * 37) % 4096, "R3 accumulate");
        end
        acc_len_m1 = 4'd15;
        for (int i = 0; i < 16; i++) push(4095, "R3 no overflow");
        check("R3 sum 65520", int'(res_data), 65520);
        // R3: shorten length mid-block
        for (int i = 0; i < 5; i++) push(100, "R3 partial");
        acc_len_m1 = 4'd2;
        push(100, "R3 shortened");

        // R4: average of four
        acc_len_m1 = 4'd3;
        for (int i = 0; i < 12; i++) push(1000 + i, "R4 avg4");

        // R5: FIR, every weight set
        set_mode(2);
        for (int s = 0; s < 4; s++) begin
            coef_sel = 2'(s);
            for (int i = 0; i < 10; i++) push((i * 1777 + s * 401) % 4096, "R5 fir");
            push(4095, "R5 fir"); push(4095, "R5 fir"); push(4095, "R5 fir fullscale");
        end

        // R6: IIR, every shift
        set_mode(3);
        for (int s = 0; s < 4; s++) begin
            coef_sel = 2'(s);
            for (int i = 0; i < 12; i++) push((i % 3 == 0) ? 4095 : (i * 311) % 4096, "R6 iir");
            for (int i = 0; i < 4; i++) push(0, "R6 iir decay");
        end

        // R7: difference sweep
        set_mode(4);
        for (int a = 0; a < 5; a++)
            for (int b = 0; b < 5; b++) begin
                ref_value = 12'(b * 1023 + (b == 4 ? 3 : 0));
                push(a * 1023 + (a == 4 ? 3 : 0), "R7 difference");
            end

        // R8: state cleared on mode change
        set_mode(2); coef_sel = 2'd0;
        push(1000, "R8 fir fill"); push(2000, "R8 fir fill");
        set_mode(0); push(5, "R8 detour");
        set_mode(2); push(400, "R8 fir first");
        check("R8 fir cleared", int'(res_data), 200);
        set_mode(3); coef_sel = 2'd0;
        push(4000, "R8 iir fill"); push(4000, "R8 iir fill");
        set_mode(4); push(5, "R8 detour");
        set_mode(3); push(4000, "R8 iir first");
        check("R8 iir cleared", int'(res_data), 2000);
        set_mode(1); acc_len_m1 = 4'd3;
        push(9, "R8 acc fill"); push(9, "R8 acc fill");
        set_mode(0); @(negedge clk);
        set_mode(1);
        for (int i = 0; i < 4; i++) push(10, "R8 acc restart");
        check("R8 acc cleared", int'(res_data), 40);

        // R9: valid flag protocol
        set_mode(0); push(42, "R9 setup");
        repeat (3) @(negedge clk);
        check("R9 sticky", int'(res_valid), 1);
        check("R9 event one cycle", int'(res_event), 0);
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
        check("R9 read clears", int'(res_valid), 0);
        rd_strobe = 1'b1; push(43, "R9 read with result"); rd_strobe = 1'b0;
        check("R9 result wins", int'(res_valid), 1);
        // R10: nothing moves without samples
        repeat (2) @(negedge clk);
        check("R10 no event", int'(res_event), 0);
        check("R10 data held", int'(res_data), 43);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule